// File: doc/BRIEF.md
# Port-Change Interrupt Generator

This block watches a parallel input port and raises an interrupt request whenever the pin levels differ from a stored reference value. The port is any width and is already synchronized to the block clock. The request is a single "pull the line low" enable. Outside the block, it drives an open-drain pad that the host wires to its interrupt input. The host learns that the port has new data without polling it over the serial bus.

The bus slave supplies three one-cycle strobes. One marks each rising edge of the serial clock. The other two mark the acknowledge bit of a read and of a write to this device. The read strobe arrives in the same cycle as the clock-rise strobe. The write strobe arrives on the clock fall of the acknowledge bit.

The output register updates only on a clock-rise strobe. At that point it shows whether the pins differ from the reference. If the pins return to the reference, the request therefore drops without any bus access. Either acknowledge strobe clears the request at once and takes the current pin value as the new reference. A pin change that lands in the same cycle as an acknowledge strobe is absorbed into the new reference and never signalled.

Top module: `port_chg_irq`

## Requirements
- R1: Out of reset, `irq_pull_o` is 0 and the reference is all ones. An all-ones port then leaves the request inactive across clock-rise strobes, and any zero pin raises it.
- R2: A rising or a falling change on any single pin is enough to make `irq_pull_o` 1 one cycle after the next `scl_rise_i` strobe, with no acknowledge strobe in that cycle.
- R3: In a cycle with no `scl_rise_i`, `rd_ack_i` or `wr_ack_i`, `irq_pull_o` holds its value whatever the pins do.
- R4: When the pins return to the reference value, `irq_pull_o` drops to 0 one cycle after the next `scl_rise_i` strobe, with no acknowledge strobe.
- R5: A `rd_ack_i` strobe (given together with `scl_rise_i`) makes `irq_pull_o` 0 in the next cycle and loads the current pins as the reference.
- R6: A `wr_ack_i` strobe, given without `scl_rise_i`, makes `irq_pull_o` 0 in the next cycle and loads the current pins as the reference.
- R7: An acknowledge strobe takes priority over a clock-rise update in the same cycle. A pin change present in that cycle becomes part of the new reference, and later clock-rise strobes do not signal it.
- R8: After a clear, a change away from the new reference raises `irq_pull_o` again at the next `scl_rise_i`. A return to the new reference drops it.
- R9: Clock-rise strobes that come without an acknowledge strobe (traffic to other devices) never move the reference. A pending request stays 1 while the pins differ from it.
- R10: With several pins changed, the request stays 1 until every pin matches the reference again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | WIDTH | Synchronized port pin levels |
| scl_rise_i | input | 1 | One-cycle strobe on each serial clock rising edge |
| rd_ack_i | input | 1 | One-cycle strobe at the acknowledge bit of a read to this device |
| wr_ack_i | input | 1 | One-cycle strobe at the acknowledge bit of a write to this device |
| irq_pull_o | output | 1 | 1 = drive the interrupt line low |

## Verification
Every result comes from one register stage. The request shows the effect of a clock-rise or acknowledge strobe in the cycle after the edge that samples that strobe. The new reference shows in the response to the next clock-rise strobe after that.

The bench changes its inputs after a falling clock edge. It holds strobes for exactly one rising edge and reads the output a short time after that edge. Each check therefore sees the result that belongs to the strobe just applied.

Checks for "no update" and "no reference move" (R3, R9) apply one or more idle or strobe-only cycles first. They then confirm the hold, and finally confirm, through a later clock-rise strobe, which reference is in force.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_RD   = 2'd1,
    CLR_WR   = 2'd2,
    CLR_BOTH = 2'd3
  } clr_src_e;

  function automatic logic is_clear(clr_src_e s);
    return s != CLR_NONE;
  endfunction
endpackage

// File: rtl/pcirq_ref.sv
module pcirq_ref #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] REF_INIT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] port_i,
  output logic [WIDTH-1:0] ref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_o <= REF_INIT;
    else if (cap_i) ref_o <= port_i;
  end
endmodule

// File: rtl/pcirq_cmp.sv
module pcirq_cmp #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] ref_i,
  output logic             diff_o
);
  logic [WIDTH-1:0] bit_diff;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign bit_diff[b] = port_i[b] ^ ref_i[b];
  end

  assign diff_o = |bit_diff;
endmodule

// File: rtl/pcirq_drive.sv
module pcirq_drive
  import pcirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clr_src_e clr_i,
  input  logic     upd_i,
  input  logic     diff_i,
  output logic     irq_o
);
  // a clear wins over a same-cycle clock-rise update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            irq_o <= 1'b0;
    else if (is_clear(clr_i)) irq_o <= 1'b0;
    else if (upd_i)         irq_o <= diff_i;
  end
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
  import pcirq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] REF_INIT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic             scl_rise_i,
  input  logic             rd_ack_i,
  input  logic             wr_ack_i,
  output logic             irq_pull_o
);
  clr_src_e         clr_src;
  logic [WIDTH-1:0] ref_q;
  logic             diff;

  assign clr_src = clr_src_e'({wr_ack_i, rd_ack_i});

  pcirq_ref #(.WIDTH(WIDTH), .REF_INIT(REF_INIT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (is_clear(clr_src)),
    .port_i (port_i),
    .ref_o  (ref_q)
  );

  pcirq_cmp #(.WIDTH(WIDTH)) u_cmp (
    .port_i (port_i),
    .ref_i  (ref_q),
    .diff_o (diff)
  );

  pcirq_drive u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_src),
    .upd_i  (scl_rise_i),
    .diff_i (diff),
    .irq_o  (irq_pull_o)
  );
endmodule

// File: rtl/port_chg_irq_chk.sv
module port_chg_irq_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] port_i,
  input logic             scl_rise_i,
  input logic             rd_ack_i,
  input logic             wr_ack_i,
  input logic             irq_pull_o,
  input logic [WIDTH-1:0] ref_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!irq_pull_o);
    end
  end

  // R3
  hold_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_rise_i && !rd_ack_i && !wr_ack_i) |=> $stable(irq_pull_o));

  // R2
  update_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise_i && !rd_ack_i && !wr_ack_i) |=> (irq_pull_o == ($past(port_i) != $past(ref_q))));

  // R5
  clear_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_i |=> (!irq_pull_o && ref_q == $past(port_i)));

  // R6
  clear_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_i |=> (!irq_pull_o && ref_q == $past(port_i)));

  // R9
  ref_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ack_i && !wr_ack_i) |=> $stable(ref_q));
endmodule

bind port_chg_irq port_chg_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .port_i     (port_i),
  .scl_rise_i (scl_rise_i),
  .rd_ack_i   (rd_ack_i),
  .wr_ack_i   (wr_ack_i),
  .irq_pull_o (irq_pull_o),
  .ref_q      (ref_q)
);

// File: tb/sim_port_chg_irq.sv
`timescale 1ns/1ps
module sim_port_chg_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port = 8'hFF;
  logic       rise = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  port_chg_irq u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .port_i     (port),
    .scl_rise_i (rise),
    .rd_ack_i   (rd),
    .wr_ack_i   (wr),
    .irq_pull_o (irq)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_pull_o=%b expected=%b (t=%0t)", req, irq, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic r, input logic a_rd, input logic a_wr);
    @(negedge clk);
    port = p; rise = r; rd = a_rd; wr = a_wr;
    @(posedge clk);
    #1;
    rise = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic set_ref(input logic [7:0] v);
    step(v, 1'b0, 1'b0, 1'b1);
    check("R6 setup", 1'b0);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0);
    step(8'hFF, 1'b1, 1'b0, 1'b0);
    check("R1 ref all ones", 1'b0);
    step(8'h7F, 1'b1, 1'b0, 1'b0);
    check("R1 zero pin raises", 1'b1);
    step(8'hFF, 1'b1, 1'b0, 1'b0);
    check("R4 back to reset ref", 1'b0);
  endtask

  task automatic t_each_bit;
    set_ref(8'hFF);
    for (int i = 0; i < 8; i++) begin
      step(8'hFF ^ (8'h01 << i), 1'b1, 1'b0, 1'b0);
      check("R2 falling pin", 1'b1);
      step(8'hFF, 1'b1, 1'b0, 1'b0);
      check("R4 return", 1'b0);
    end
    set_ref(8'h00);
    for (int i = 0; i < 8; i++) begin
      step(8'h01 << i, 1'b1, 1'b0, 1'b0);
      check("R2 rising pin", 1'b1);
      step(8'h00, 1'b1, 1'b0, 1'b0);
      check("R4 return", 1'b0);
    end
  endtask

  task automatic t_no_strobe;
    set_ref(8'hA5);
    step(8'hA4, 1'b0, 1'b0, 1'b0);
    check("R3 no strobe", 1'b0);
    step(8'hA4, 1'b0, 1'b0, 1'b0);
    check("R3 no strobe", 1'b0);
    step(8'hA4, 1'b1, 1'b0, 1'b0);
    check("R2 strobe", 1'b1);
    step(8'hA5, 1'b0, 1'b0, 1'b0);
    check("R3 hold high", 1'b1);
    step(8'hA5, 1'b1, 1'b0, 1'b0);
    check("R4 self clear", 1'b0);
  endtask

  task automatic t_read_clear;
    set_ref(8'h0F);
    step(8'h1F, 1'b1, 1'b0, 1'b0);
    check("R5 pre", 1'b1);
    step(8'h1F, 1'b1, 1'b1, 1'b0);
    check("R5 read clear", 1'b0);
    step(8'h1F, 1'b1, 1'b0, 1'b0);
    check("R5 ref loaded", 1'b0);
  endtask

  task automatic t_write_clear;
    set_ref(8'h0F);
    step(8'h0E, 1'b1, 1'b0, 1'b0);
    check("R6 pre", 1'b1);
    step(8'h0E, 1'b0, 1'b0, 1'b1);
    check("R6 write clear", 1'b0);
    step(8'h0E, 1'b1, 1'b0, 1'b0);
    check("R6 ref loaded", 1'b0);
  endtask

  task automatic t_lost_change;
    set_ref(8'h33);
    step(8'h32, 1'b1, 1'b1, 1'b0);
    check("R7 clear wins", 1'b0);
    step(8'h32, 1'b1, 1'b0, 1'b0);
    check("R7 change absorbed rd", 1'b0);
    step(8'h30, 1'b0, 1'b0, 1'b1);
    check("R7 clear wins wr", 1'b0);
    step(8'h30, 1'b1, 1'b0, 1'b0);
    check("R7 change absorbed wr", 1'b0);
  endtask

  task automatic t_rearm;
    set_ref(8'h32);
    step(8'h72, 1'b1, 1'b0, 1'b0);
    check("R8 rearmed", 1'b1);
    step(8'h32, 1'b1, 1'b0, 1'b0);
    check("R8 back to new ref", 1'b0);
    step(8'h33, 1'b1, 1'b0, 1'b0);
    check("R8 old ref is a change", 1'b1);
  endtask

  task automatic t_other_traffic;
    set_ref(8'h55);
    step(8'h54, 1'b1, 1'b0, 1'b0);
    check("R9 pre", 1'b1);
    for (int k = 0; k < 5; k++) begin
      step(8'h54, 1'b1, 1'b0, 1'b0);
      check("R9 stays pending", 1'b1);
    end
    step(8'h55, 1'b1, 1'b0, 1'b0);
    check("R9 ref unmoved", 1'b0);
  endtask

  task automatic t_multi;
    set_ref(8'h00);
    step(8'hC3, 1'b1, 1'b0, 1'b0);
    check("R10 multi", 1'b1);
    step(8'hC0, 1'b1, 1'b0, 1'b0);
    check("R10 partial return", 1'b1);
    step(8'h00, 1'b1, 1'b0, 1'b0);
    check("R10 full return", 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    #5;
    check("R1 in reset", 1'b0);
    #50;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_each_bit();
    t_no_strobe();
    t_read_clear();
    t_write_clear();
    t_lost_change();
    t_rearm();
    t_other_traffic();
    t_multi();
    finish_run();
  end
endmodule